// File: doc/BRIEF.md
# GHASH Key Power Table Generator

This block turns a 128-bit GHASH hash key into a small table of key powers for aggregated hashing. A hashing engine can then fold several data blocks into one reduction. All field arithmetic uses the bit-reflected representation: bit i of a 128-bit word is the coefficient of x^i. In that domain the field product of a and b is a·b·x^-127 mod x^128+x^127+x^126+x^121+1.

A one-cycle load strobe presents the key and the table length. The block first doubles the key modulo the reflected polynomial and stores the result as entry 0. It then fills each later entry with entry 0 times the previous entry. A single iterative multiplier computes these products, a few bits per clock. The whole table sits in registers behind a combinational read port. That port reports whether the entry it shows belongs to a finished table. A new load abandons any table still being built and starts over.

Top module: `ghk_powers`

## Requirements
- R1: While reset is asserted and after it is released with no load, `ready_o` is 0, `rd_stale_o` is 1, and every entry reads as all zeros.
- R2: On the clock edge that samples `load_i`, entry 0 is written with the key shifted left by one bit (bit 0 becomes 0, and bit 63 moves into bit 64). When bit 127 of the key was 1, that shifted value is also XORed with 0xC2000000_00000000_00000000_00000001. Entry 0 is readable in the next cycle.
- R3: `count_m1_i` holds the table length minus one: value k requests N = k+1 entries, so 0 means one entry and 7 means eight. The value is sampled together with `load_i`.
- R4: For 1 ≤ i < N, entry i is the reflected-domain field product of entry 0 and entry i-1, so entry i is the (i+1)-th power of entry 0.
- R5: Entry i is written on the edge i·(128/BITS_PER_CYCLE + 2) cycles after the load edge. `ready_o` rises on the edge that writes entry N-1, which is the load edge itself when N = 1. It then stays high until the next load.
- R6: `rd_data_o` shows the current content of entry `rd_idx_i` combinationally. `rd_stale_o` is 1 whenever `ready_o` is 0 or `rd_idx_i` ≥ N, and 0 otherwise.
- R7: A load while a table is still being built discards that work. It restarts from entry 0 with the new key and length, and `ready_o` follows R5 for the new load only.
- R8: A sequence never writes entries at index N or above. They keep whatever an earlier sequence left there.
- R9: A load while `ready_o` is high starts a fresh sequence exactly like a load from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle strobe: take a new key and length |
| key_i | input | 128 | Hash key in reflected bit order |
| count_m1_i | input | 3 | Table length minus one |
| rd_idx_i | input | 3 | Entry index for the read port |
| rd_data_o | output | 128 | Content of the selected entry |
| rd_stale_o | output | 1 | Selected entry is not part of a finished table |
| ready_o | output | 1 | All requested entries have been written |

## Verification
Two keys exercise the doubling step: one with bit 127 set, which needs the polynomial fold, and one with it clear, which must not be folded. A full eight-entry chain is followed by a three-entry chain. Comparing the two shows that entries past the requested length keep their old content, and that the read port flags them as stale. A load arriving mid-chain and a one-entry load issued while the table is ready separate the restart rules from the normal completion timing. An all-ones key gives a dense operand to the multiply and reduction path. The read index rotates every cycle, so stale and fresh entries are both compared at every stage of filling.

// File: rtl/ghk_pkg.sv
package ghk_pkg;
  localparam int unsigned BLK_W = 128;
  typedef logic [BLK_W-1:0] blk_t;

  // fold applied when doubling pushes a coefficient past x^127
  localparam blk_t FOLD_C = {64'hC200_0000_0000_0000, 64'h0000_0000_0000_0001};
  // reflected polynomial divided by x, with its x^0 term dropped
  localparam blk_t DIVX_C = {8'hE1, 120'h0};

  typedef enum logic [1:0] {
    S_IDLE,
    S_KICK,
    S_WAIT,
    S_DONE
  } seq_st_e;
endpackage

// File: rtl/ghk_prescale.sv
module ghk_prescale
  import ghk_pkg::*;
(
  input  blk_t key_i,
  output blk_t hprime_o
);
  logic carry_out;
  blk_t doubled;

  always_comb begin
    carry_out = key_i[BLK_W-1];
    doubled   = {key_i[BLK_W-2:0], 1'b0};
    hprime_o  = carry_out ? (doubled ^ FOLD_C) : doubled;
  end
endmodule

// File: rtl/ghk_rmul.sv
// Iterative reflected-domain multiplier: a*b*x^-127 mod RPOLY.
// Bits of a are consumed LSB first; each step divides the running sum
// by x before adding a_k*b, so bit 0 ends up weighted by x^-127.
module ghk_rmul
  import ghk_pkg::*;
#(
  parameter int unsigned BPC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic start_i,
  input  blk_t a_i,
  input  blk_t b_i,
  output logic busy_o,
  output logic done_o,
  output blk_t prod_o
);
  localparam int unsigned STEPS = BLK_W / BPC;
  localparam int unsigned CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  blk_t acc_q, acc_d;
  blk_t opa_q, opa_d;
  blk_t opb_q, opb_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d;
  logic done_q, done_d;
  logic op_en;

  blk_t chain [BPC+1];
  assign chain[0] = acc_q;

  for (genvar g = 0; g < BPC; g++) begin : g_step
    blk_t divided;
    assign divided    = {1'b0, chain[g][BLK_W-1:1]} ^ (chain[g][0] ? DIVX_C : '0);
    assign chain[g+1] = divided ^ (opa_q[g] ? opb_q : '0);
  end

  always_comb begin
    acc_d  = acc_q;
    opa_d  = opa_q;
    opb_d  = opb_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (clear_i) begin
      busy_d = 1'b0;
    end else if (start_i) begin
      acc_d  = '0;
      opa_d  = a_i;
      opb_d  = b_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      acc_d = chain[BPC];
      opa_d = opa_q >> BPC;
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign op_en = start_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      cnt_q <= '0;
    end else if (op_en) begin
      acc_q <= acc_d;
      opa_q <= opa_d;
      opb_q <= opb_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/ghk_table.sv
module ghk_table
  import ghk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  blk_t          wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output blk_t          rd_data_o,
  input  logic [IW-1:0] opb_idx_i,
  output blk_t          opb_data_o,
  output blk_t          base_o
);
  blk_t ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic we;
    blk_t q;
    assign we = wr_en_i && (wr_idx_i == IW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we) begin
        q <= wr_data_i;
      end
    end
    assign ent[e] = q;
  end

  assign rd_data_o  = ent[rd_idx_i];
  assign opb_data_o = ent[opb_idx_i];
  assign base_o     = ent[0];
endmodule

// File: rtl/ghk_seq.sv
module ghk_seq
  import ghk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [IW-1:0] nm1_i,
  input  logic          mul_done_i,
  output logic          mul_start_o,
  output logic          mul_clear_o,
  output logic          wr_en_o,
  output logic          wr_sel_key_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [IW-1:0] opb_idx_o,
  output logic [IW-1:0] nm1_o,
  output logic          ready_o
);
  seq_st_e       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] nm1_q, nm1_d;

  always_comb begin
    st_d         = st_q;
    idx_d        = idx_q;
    nm1_d        = nm1_q;
    mul_start_o  = 1'b0;
    wr_en_o      = 1'b0;
    wr_sel_key_o = 1'b0;
    wr_idx_o     = idx_q;
    if (load_i) begin
      nm1_d        = nm1_i;
      idx_d        = IW'(1);
      wr_en_o      = 1'b1;
      wr_sel_key_o = 1'b1;
      wr_idx_o     = '0;
      st_d         = (nm1_i == '0) ? S_DONE : S_KICK;
    end else begin
      case (st_q)
        S_KICK: begin
          mul_start_o = 1'b1;
          st_d        = S_WAIT;
        end
        S_WAIT: begin
          if (mul_done_i) begin
            wr_en_o = 1'b1;
            if (idx_q == nm1_q) begin
              st_d = S_DONE;
            end else begin
              idx_d = idx_q + IW'(1);
              st_d  = S_KICK;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      nm1_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      nm1_q <= nm1_d;
    end
  end

  assign mul_clear_o = load_i;
  assign opb_idx_o   = idx_q - IW'(1);
  assign nm1_o       = nm1_q;
  assign ready_o     = (st_q == S_DONE);
endmodule

// File: rtl/ghk_powers.sv
module ghk_powers
  import ghk_pkg::*;
#(
  parameter int unsigned MAX_POWERS     = 8,
  parameter int unsigned BITS_PER_CYCLE = 4,
  localparam int unsigned IW = (MAX_POWERS > 1) ? $clog2(MAX_POWERS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [127:0]  key_i,
  input  logic [IW-1:0] count_m1_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [127:0]  rd_data_o,
  output logic          rd_stale_o,
  output logic          ready_o
);
  blk_t          hprime;
  blk_t          prod;
  blk_t          base;
  blk_t          opb;
  blk_t          wr_data;
  logic          mul_busy;
  logic          mul_done;
  logic          mul_start;
  logic          mul_clear;
  logic          wr_en;
  logic          wr_sel_key;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] opb_idx;
  logic [IW-1:0] nm1;

  ghk_prescale u_pre (
    .key_i    (key_i),
    .hprime_o (hprime)
  );

  ghk_seq #(.DEPTH(MAX_POWERS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .nm1_i        (count_m1_i),
    .mul_done_i   (mul_done),
    .mul_start_o  (mul_start),
    .mul_clear_o  (mul_clear),
    .wr_en_o      (wr_en),
    .wr_sel_key_o (wr_sel_key),
    .wr_idx_o     (wr_idx),
    .opb_idx_o    (opb_idx),
    .nm1_o        (nm1),
    .ready_o      (ready_o)
  );

  ghk_rmul #(.BPC(BITS_PER_CYCLE)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (mul_clear),
    .start_i (mul_start),
    .a_i     (base),
    .b_i     (opb),
    .busy_o  (mul_busy),
    .done_o  (mul_done),
    .prod_o  (prod)
  );

  assign wr_data = wr_sel_key ? hprime : prod;

  ghk_table #(.DEPTH(MAX_POWERS)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o),
    .opb_idx_i  (opb_idx),
    .opb_data_o (opb),
    .base_o     (base)
  );

  assign rd_stale_o = !ready_o || (rd_idx_i > nm1);
endmodule

// File: rtl/ghk_powers_chk.sv
module ghk_powers_chk #(
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [127:0]  key_i,
  input logic [IW-1:0] count_m1_i,
  input logic [IW-1:0] rd_idx_i,
  input logic [127:0]  rd_data_o,
  input logic          rd_stale_o,
  input logic          ready_o,
  input logic          mul_busy,
  input logic          mul_done
);
  // R6: nothing is presented as fresh before the table is complete
  p_stale_until_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> rd_stale_o);

  // R3: a one-entry request is complete right after the load edge
  p_short_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ready_o == ($past(count_m1_i) == '0)));

  // R2: bit 0 of entry 0 carries the old top bit, bit 1 the old bit 0
  p_entry0_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ((rd_idx_i != '0) ||
                ((rd_data_o[0] == $past(key_i[127])) && (rd_data_o[1] == $past(key_i[0])))));

  // R5: completion is held until another load
  p_ready_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !load_i) |=> ready_o);

  // R5: a complete table has no multiply in flight
  p_ready_idle_mul_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!mul_busy && !mul_done));

  // R7: a load cancels the multiply in progress
  p_load_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !mul_busy);
endmodule

bind ghk_powers ghk_powers_chk #(.IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .key_i      (key_i),
  .count_m1_i (count_m1_i),
  .rd_idx_i   (rd_idx_i),
  .rd_data_o  (rd_data_o),
  .rd_stale_o (rd_stale_o),
  .ready_o    (ready_o),
  .mul_busy   (mul_busy),
  .mul_done   (mul_done)
);

// File: tb/ghk_powers_test.sv
module ghk_powers_test;
  localparam int MAXP = 8;
  localparam int BPC  = 4;
  localparam int SLOT = 128 / BPC + 2;
  localparam int WATCHDOG_CYC = 200000;

  logic         clk;
  logic         rst_n;
  logic         load_i;
  logic [127:0] key_i;
  logic [2:0]   count_m1_i;
  logic [2:0]   rd_idx_i;
  logic [127:0] rd_data_o;
  logic         rd_stale_o;
  logic         ready_o;

  ghk_powers #(.MAX_POWERS(MAXP), .BITS_PER_CYCLE(BPC)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .key_i      (key_i),
    .count_m1_i (count_m1_i),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o),
    .rd_stale_o (rd_stale_o),
    .ready_o    (ready_o)
  );

  // 8 time units per period: 125 MHz with 1 ns units
  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_vec;
  int    n_bad;
  int    cyc;
  bit    finished;
  string phase;

  // ---------------- behavioural reference ----------------
  logic [127:0] m_tab [MAXP];
  bit           m_ready;
  bit           m_run;
  int           m_nm1;
  int           m_next;
  int           m_t;

  function automatic logic [127:0] ref_double(input logic [127:0] k);
    logic [127:0] r;
    r = k << 1;
    if (k[127]) r = r ^ {64'hC200_0000_0000_0000, 64'h1};
    return r;
  endfunction

  // a*b*x^-127 mod (x^128+x^127+x^126+x^121+1), bit i = coeff of x^i
  function automatic logic [127:0] ref_fmul(input logic [127:0] a, input logic [127:0] b);
    logic [255:0] p;
    logic [255:0] rp;
    p  = '0;
    rp = (256'h1 << 128) | (256'h1 << 127) | (256'h1 << 126) | (256'h1 << 121) | 256'h1;
    for (int i = 0; i < 128; i++)
      if (b[i]) p = p ^ ({128'h0, a} << i);
    for (int j = 0; j < 127; j++) begin
      if (p[0]) p = p ^ rp;
      p = p >> 1;
    end
    return p[127:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < MAXP; e++) m_tab[e] = '0;
      m_ready = 0; m_run = 0; m_nm1 = 0; m_next = 0; m_t = 0;
    end else if (load_i) begin
      m_tab[0] = ref_double(key_i);
      m_nm1    = int'(count_m1_i);
      m_next   = 1;
      m_t      = 0;
      m_ready  = (count_m1_i == 3'd0);
      m_run    = (count_m1_i != 3'd0);
    end else if (m_run) begin
      m_t++;
      if (m_t == SLOT) begin
        m_t = 0;
        m_tab[m_next] = ref_fmul(m_tab[0], m_tab[m_next-1]);
        if (m_next == m_nm1) begin
          m_run = 0;
          m_ready = 1;
        end else begin
          m_next++;
        end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic compare();
    bit exp_stale;
    int ix;
    ix = int'(rd_idx_i);
    exp_stale = !m_ready || (ix > m_nm1);
    n_vec++;
    if (ready_o !== m_ready) begin
      n_bad++;
      $display("FAIL R5 [%s] cyc %0d ready_o got %0b expected %0b", phase, cyc, ready_o, m_ready);
    end
    n_vec++;
    if (rd_stale_o !== exp_stale) begin
      n_bad++;
      $display("FAIL R6 [%s] cyc %0d idx %0d rd_stale_o got %0b expected %0b",
               phase, cyc, ix, rd_stale_o, exp_stale);
    end
    n_vec++;
    if (rd_data_o !== m_tab[ix]) begin
      n_bad++;
      if (ix == 0)
        $display("FAIL R2 [%s] cyc %0d entry 0 got %h expected %h", phase, cyc, rd_data_o, m_tab[ix]);
      else
        $display("FAIL R4 [%s] cyc %0d entry %0d got %h expected %h", phase, cyc, ix, rd_data_o, m_tab[ix]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    cyc++;
    rd_idx_i = 3'(cyc % MAXP);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_load(input logic [127:0] k, input logic [2:0] c);
    load_i     = 1'b1;
    key_i      = k;
    count_m1_i = c;
    step();
    load_i     = 1'b0;
    key_i      = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(WATCHDOG_CYC * 8);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; cyc = 0; finished = 0;
    load_i = 0; key_i = '0; count_m1_i = '0; rd_idx_i = '0;
    rst_n = 1'b0;
    phase = "R1 reset";
    run(4);
    rst_n = 1'b1;
    run(8);

    // R2 fold case (bit 127 set), R4 full chain, R5 timing
    phase = "R4 eight entries";
    do_load(128'hF0E1D2C3B4A5968778695A4B3C2D1E0F, 3'd7);
    run(7 * SLOT + 12);

    // R2 no-fold case, R3 short length, R8 upper entries untouched, R9 load while ready
    phase = "R8 three entries";
    do_load(128'h66E94BD4EF8A2C3B884CFA59CA342B2E, 3'd2);
    run(2 * SLOT + 16);

    // R7 abort mid-chain
    phase = "R7 abort";
    do_load(128'h0123456789ABCDEFFEDCBA9876543210, 3'd7);
    run(SLOT + 9);
    do_load(128'hA5A5A5A55A5A5A5AC3C3C3C33C3C3C3C, 3'd4);
    run(4 * SLOT + 10);

    // R3 one-entry table, R9 load while ready
    phase = "R3 single entry";
    do_load(128'h8000_0000_0000_0000_0000_0000_0000_0001, 3'd0);
    run(12);

    // dense operand: all ones
    phase = "R4 all ones";
    do_load({128{1'b1}}, 3'd1);
    run(SLOT + 10);

    finished = 1;
    summary();
    $finish;
  end
endmodule